// File: doc/BRIEF.md
# Windowed Integer Register File

This block is an integer register file whose 32 architectural registers are viewed through a movable window. Registers 0-7 are shared by every window. Registers 8-31 select entries inside a ring of physical windows chosen by a current window pointer. Each window owns eight private locals. Its eight outgoing registers are the same storage as the eight incoming registers of the next window in the ring. Because of this overlap, a caller's arguments appear in the callee's inputs after a window advance, and no data is copied.

A window advance (`save_i`) and a window retreat (`restore_i`) are gated by two availability counters, one for free windows and one for restorable windows. A third counter holds windows that belong to another context. The three counters always add up to the number of windows minus two. When the needed counter is zero, the request is refused. The pointer and counters stay as they were, and a one-cycle overflow or underflow flag is raised so that a handler can spill or fill memory. A direct counter-load port lets the environment adjust the counters the way such a handler would.

Top module: `win_regfile`

## Requirements
- R1: Architectural register 0 always reads as zero. A write to register 0 changes no storage.
- R2: Registers 1-7 are global: a value written in any window reads back unchanged from every other window.
- R3: Registers 8-15 (outputs) of window w are the same storage as registers 24-31 (inputs) of window (w+1) mod NWIN. This includes the wrap from window NWIN-1 to window 0.
- R4: Registers 16-23 (locals) are private. A write in one window is not visible in any other window.
- R5: An accepted save adds one to the window pointer modulo NWIN, takes one from the free-window counter and adds one to the restorable-window counter.
- R6: A save while the free-window counter is 0 leaves the pointer and all counters unchanged. It drives `overflow_o` high for exactly the cycle after the request edge.
- R7: An accepted restore takes one from the window pointer modulo NWIN, adds one to the free-window counter and takes one from the restorable-window counter.
- R8: A restore while the restorable-window counter is 0 leaves the pointer and all counters unchanged. It drives `underflow_o` high for exactly the cycle after the request edge.
- R9: At every cycle out of reset, free + restorable + other = NWIN-2.
- R10: After reset, the pointer is 0, the free-window counter is NWIN-2, the other two counters are 0, and both flags are low.
- R11: Reads are combinational. A read of the storage entry being written in the same cycle returns the new write data. Storage entries are compared after window mapping, so an alias also forwards.
- R12: With `cnt_we_i` high, the three counters load from the load inputs only if the loaded values sum to NWIN-2. Otherwise the load is ignored. In either case, save and restore are ignored in that cycle and the window pointer is kept.
- R13: When save and restore are both requested in one cycle, save is executed and restore is ignored.
- R14: Writes and reads in a cycle use the window pointer held before that cycle's save or restore takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 5 | Read port A architectural register |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_addr_i | input | 5 | Read port B architectural register |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write architectural register |
| wr_data_i | input | DATA_W | Write data |
| save_i | input | 1 | Advance-window request |
| restore_i | input | 1 | Retreat-window request |
| cnt_we_i | input | 1 | Counter load strobe |
| cnt_cansave_i | input | $clog2(NWIN) | Free-window counter load value |
| cnt_canrestore_i | input | $clog2(NWIN) | Restorable-window counter load value |
| cnt_otherwin_i | input | $clog2(NWIN) | Other-window counter load value |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| cansave_o | output | $clog2(NWIN) | Free-window counter |
| canrestore_o | output | $clog2(NWIN) | Restorable-window counter |
| otherwin_o | output | $clog2(NWIN) | Other-window counter |
| overflow_o | output | 1 | Save refused in previous cycle |
| underflow_o | output | 1 | Restore refused in previous cycle |

## Verification
The hardest case to reach is the overlap across the ring wrap. Window NWIN-1's outputs must show up as window 0's inputs. After reset the free counter allows only NWIN-2 advances, so the pointer never reaches NWIN-1 through saves alone. The stimulus uses the counter-load port, the way a spill handler would, to grant extra free windows, then steps past the wrap and reads back. Random traffic then mixes loads, saves, restores and same-entry read/write, and a bench model of the storage checks every read.

// File: rtl/win_regfile_pkg.sv
package win_regfile_pkg;
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } reg_grp_e;

  localparam int unsigned NUM_GLB   = 8;
  localparam int unsigned WIN_SLOTS = 16;

  function automatic reg_grp_e grp_of(input logic [4:0] a);
    return reg_grp_e'(a[4:3]);
  endfunction
endpackage

// File: rtl/win_map.sv
module win_map
  import win_regfile_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = $clog2(NWIN),
  parameter int unsigned PA_W  = $clog2(NUM_GLB + WIN_SLOTS * NWIN)
) (
  input  logic [4:0]       arch_i,
  input  logic [CWP_W-1:0] cwp_i,
  output logic [PA_W-1:0]  phys_o
);
  reg_grp_e         grp;
  logic [CWP_W-1:0] win_sel;
  logic [PA_W-1:0]  base;
  logic [PA_W-1:0]  slot;

  always_comb begin
    grp     = grp_of(arch_i);
    // outputs live in the next window's input slots; CWP_W-bit add wraps mod NWIN
    win_sel = (grp == GRP_OUT) ? cwp_i + 1'b1 : cwp_i;
    base    = PA_W'(NUM_GLB) + (PA_W'(win_sel) << 4);
    slot    = PA_W'(arch_i[2:0]);
    unique case (grp)
      GRP_GLB: phys_o = slot;
      GRP_LOC: phys_o = base + PA_W'(8) + slot;
      default: phys_o = base + slot;
    endcase
  end
endmodule

// File: rtl/win_ctrl.sv
module win_ctrl #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned CWP_W = $clog2(NWIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             cnt_we_i,
  input  logic [CWP_W-1:0] cs_ld_i,
  input  logic [CWP_W-1:0] cr_ld_i,
  input  logic [CWP_W-1:0] ow_ld_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic [CWP_W-1:0] cansave_o,
  output logic [CWP_W-1:0] canrestore_o,
  output logic [CWP_W-1:0] otherwin_o,
  output logic             overflow_o,
  output logic             underflow_o
);
  localparam int unsigned SUM_W = CWP_W + 2;
  localparam logic [SUM_W-1:0] SUM_REF = SUM_W'(NWIN - 2);
  localparam logic [CWP_W-1:0] CS_RST  = CWP_W'(NWIN - 2);

  logic [SUM_W-1:0] ld_sum;
  logic             ld_ok;
  logic             do_save, do_rest;

  always_comb begin
    ld_sum  = SUM_W'(cs_ld_i) + SUM_W'(cr_ld_i) + SUM_W'(ow_ld_i);
    ld_ok   = (ld_sum == SUM_REF);
    do_save = !cnt_we_i && save_i;
    do_rest = !cnt_we_i && !save_i && restore_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_o        <= '0;
      cansave_o    <= CS_RST;
      canrestore_o <= '0;
      otherwin_o   <= '0;
      overflow_o   <= 1'b0;
      underflow_o  <= 1'b0;
    end else begin
      overflow_o  <= do_save && (cansave_o == '0);
      underflow_o <= do_rest && (canrestore_o == '0);
      if (cnt_we_i) begin
        if (ld_ok) begin
          cansave_o    <= cs_ld_i;
          canrestore_o <= cr_ld_i;
          otherwin_o   <= ow_ld_i;
        end
      end else if (do_save) begin
        if (cansave_o != '0) begin
          cwp_o        <= cwp_o + 1'b1;
          cansave_o    <= cansave_o - 1'b1;
          canrestore_o <= canrestore_o + 1'b1;
        end
      end else if (do_rest) begin
        if (canrestore_o != '0) begin
          cwp_o        <= cwp_o - 1'b1;
          cansave_o    <= cansave_o + 1'b1;
          canrestore_o <= canrestore_o - 1'b1;
        end
      end
    end
  end

  assert_sum_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SUM_W'(cansave_o) + SUM_W'(canrestore_o) + SUM_W'(otherwin_o)) == SUM_REF);

  assert_save_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !cnt_we_i && cansave_o != '0) |=>
      (cwp_o == CWP_W'($past(cwp_o) + 1'b1)) && !overflow_o);

  assert_no_overflow_move_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !cnt_we_i && cansave_o == '0) |=>
      overflow_o && $stable(cwp_o) && $stable(cansave_o) && $stable(canrestore_o));

  assert_rest_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !cnt_we_i && canrestore_o != '0) |=>
      (cwp_o == CWP_W'($past(cwp_o) - 1'b1)) && !underflow_o);

  assert_no_underflow_move_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !cnt_we_i && canrestore_o == '0) |=>
      underflow_o && $stable(cwp_o) && $stable(canrestore_o));

  assert_load_keeps_cwp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> $stable(cwp_o) && !overflow_o && !underflow_o);

  assert_flags_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({overflow_o, underflow_o}));
endmodule

// File: rtl/win_store.sv
module win_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 136,
  parameter int unsigned PA_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PA_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PA_W-1:0]   raddr_a_i,
  input  logic [PA_W-1:0]   raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_comb begin
    rdata_a_o = (we_i && waddr_i == raddr_a_i) ? wdata_i : mem[raddr_a_i];
    rdata_b_o = (we_i && waddr_i == raddr_b_i) ? wdata_i : mem[raddr_b_i];
  end

  // a write is visible from the array on the following cycle
  assert_wr_then_rd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((raddr_a_i != $past(waddr_i)) || (we_i && waddr_i == raddr_a_i) ||
              (rdata_a_o == $past(wdata_i))));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import win_regfile_pkg::*;
#(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [4:0]               rd_a_addr_i,
  output logic [DATA_W-1:0]        rd_a_data_o,
  input  logic [4:0]               rd_b_addr_i,
  output logic [DATA_W-1:0]        rd_b_data_o,
  input  logic                     wr_en_i,
  input  logic [4:0]               wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     save_i,
  input  logic                     restore_i,
  input  logic                     cnt_we_i,
  input  logic [$clog2(NWIN)-1:0]  cnt_cansave_i,
  input  logic [$clog2(NWIN)-1:0]  cnt_canrestore_i,
  input  logic [$clog2(NWIN)-1:0]  cnt_otherwin_i,
  output logic [$clog2(NWIN)-1:0]  cwp_o,
  output logic [$clog2(NWIN)-1:0]  cansave_o,
  output logic [$clog2(NWIN)-1:0]  canrestore_o,
  output logic [$clog2(NWIN)-1:0]  otherwin_o,
  output logic                     overflow_o,
  output logic                     underflow_o
);
  localparam int unsigned CWP_W = $clog2(NWIN);
  localparam int unsigned DEPTH = NUM_GLB + WIN_SLOTS * NWIN;
  localparam int unsigned PA_W  = $clog2(DEPTH);

  initial begin
    assert_nwin_legal: assert ((NWIN >= 4) && (NWIN <= 32) && ((NWIN & (NWIN - 1)) == 0));
  end

  logic [PA_W-1:0]   pa_a, pa_b, pa_w;
  logic [DATA_W-1:0] st_a, st_b;
  logic              st_we;

  win_ctrl #(.NWIN(NWIN), .CWP_W(CWP_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .save_i       (save_i),
    .restore_i    (restore_i),
    .cnt_we_i     (cnt_we_i),
    .cs_ld_i      (cnt_cansave_i),
    .cr_ld_i      (cnt_canrestore_i),
    .ow_ld_i      (cnt_otherwin_i),
    .cwp_o        (cwp_o),
    .cansave_o    (cansave_o),
    .canrestore_o (canrestore_o),
    .otherwin_o   (otherwin_o),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
  );

  win_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PA_W(PA_W)) u_map_a (
    .arch_i (rd_a_addr_i), .cwp_i (cwp_o), .phys_o (pa_a));
  win_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PA_W(PA_W)) u_map_b (
    .arch_i (rd_b_addr_i), .cwp_i (cwp_o), .phys_o (pa_b));
  win_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PA_W(PA_W)) u_map_w (
    .arch_i (wr_addr_i), .cwp_i (cwp_o), .phys_o (pa_w));

  assign st_we = wr_en_i && (wr_addr_i != 5'd0);

  win_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PA_W(PA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (st_we),
    .waddr_i   (pa_w),
    .wdata_i   (wr_data_i),
    .raddr_a_i (pa_a),
    .raddr_b_i (pa_b),
    .rdata_a_o (st_a),
    .rdata_b_o (st_b)
  );

  assign rd_a_data_o = (rd_a_addr_i == 5'd0) ? '0 : st_a;
  assign rd_b_data_o = (rd_b_addr_i == 5'd0) ? '0 : st_b;

  // same architectural input-register, window advanced by one, reads what was written to an output
  assert_out_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[4:3] == 2'b01 && save_i && !cnt_we_i && cansave_o != '0) |=>
      ((rd_a_addr_i != {2'b11, $past(wr_addr_i[2:0])}) || (wr_en_i && wr_addr_i == rd_a_addr_i) ||
       (rd_a_data_o == $past(wr_data_i))));
endmodule

// File: tb/win_regfile_bench.sv
module win_regfile_bench;
  localparam int NWIN   = 8;
  localparam int DATA_W = 32;
  localparam int CWP_W  = 3;
  localparam int DEPTH  = 8 + 16 * NWIN;
  localparam int PERIOD = 10;

  logic              clk, rst_n;
  logic [4:0]        rda, rdb, wa;
  logic [DATA_W-1:0] qa, qb, wd;
  logic              we, sv, rs, cw;
  logic [CWP_W-1:0]  cs_ld, cr_ld, ow_ld, cwp, cs, cr, ow;
  logic              ovf, unf;

  win_regfile #(.NWIN(NWIN), .DATA_W(DATA_W)) u_win_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_addr_i(rda), .rd_a_data_o(qa), .rd_b_addr_i(rdb), .rd_b_data_o(qb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .save_i(sv), .restore_i(rs), .cnt_we_i(cw),
    .cnt_cansave_i(cs_ld), .cnt_canrestore_i(cr_ld), .cnt_otherwin_i(ow_ld),
    .cwp_o(cwp), .cansave_o(cs), .canrestore_o(cr), .otherwin_o(ow),
    .overflow_o(ovf), .underflow_o(unf));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DATA_W-1:0] m_mem [DEPTH];
  bit                m_vld [DEPTH];
  int m_cwp, m_cs, m_cr, m_ow;
  bit m_ovf, m_unf;

  initial clk = 0;
  always #(PERIOD/2) clk = ~clk;

  function automatic int phys(int w, int r);
    if (r < 8) return r;
    if (r < 16) return 8 + 16 * ((w + 1) % NWIN) + (r - 8);
    if (r < 24) return 8 + 16 * w + 8 + (r - 16);
    return 8 + 16 * w + (r - 24);
  endfunction

  function automatic string rd_tag(int r);
    if (r == 0) return "R1";
    if (r < 8) return "R2";
    if (r >= 16 && r < 24) return "R4";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rd(int r, logic [DATA_W-1:0] got, bit w_en, int w_a, logic [DATA_W-1:0] w_d);
    int p;
    p = phys(m_cwp, r);
    if (r == 0) begin
      chk(got == '0, "R1", got, 0);
    end else if (w_en && w_a != 0 && phys(m_cwp, w_a) == p) begin
      chk(got == w_d, "R11", got, w_d);
    end else if (m_vld[p]) begin
      chk(got == m_mem[p], rd_tag(r), got, m_mem[p]);
    end
  endtask

  task automatic step(int a, int b, bit w_en, int w_a, logic [DATA_W-1:0] w_d,
                      bit s, bit r, bit c, int c_s, int c_r, int c_o);
    string tag;
    @(negedge clk);
    rda = 5'(a); rdb = 5'(b); we = w_en; wa = 5'(w_a); wd = w_d;
    sv = s; rs = r; cw = c; cs_ld = CWP_W'(c_s); cr_ld = CWP_W'(c_r); ow_ld = CWP_W'(c_o);
    #1;
    chk_rd(a, qa, w_en, w_a, w_d);
    chk_rd(b, qb, w_en, w_a, w_d);
    // model update: write uses pre-edge pointer (R14)
    if (w_en && w_a != 0) begin
      m_mem[phys(m_cwp, w_a)] = w_d;
      m_vld[phys(m_cwp, w_a)] = 1;
    end
    m_ovf = 0; m_unf = 0;
    if (c) begin
      tag = "R12";
      if (c_s + c_r + c_o == NWIN - 2) begin m_cs = c_s; m_cr = c_r; m_ow = c_o; end
    end else if (s) begin
      tag = r ? "R13" : (m_cs == 0 ? "R6" : "R5");
      if (m_cs == 0) m_ovf = 1;
      else begin m_cwp = (m_cwp + 1) % NWIN; m_cs--; m_cr++; end
    end else if (r) begin
      tag = (m_cr == 0) ? "R8" : "R7";
      if (m_cr == 0) m_unf = 1;
      else begin m_cwp = (m_cwp + NWIN - 1) % NWIN; m_cs++; m_cr--; end
    end else tag = "R9";
    @(posedge clk);
    #1;
    chk(cwp == CWP_W'(m_cwp), tag, cwp, m_cwp);
    chk(cs == CWP_W'(m_cs) && cr == CWP_W'(m_cr) && ow == CWP_W'(m_ow), tag,
        {cs, cr, ow}, {3'(m_cs), 3'(m_cr), 3'(m_ow)});
    chk(ovf == m_ovf && unf == m_unf, tag, {ovf, unf}, {m_ovf, m_unf});
    chk(int'(cs) + int'(cr) + int'(ow) == NWIN - 2, "R9", int'(cs) + int'(cr) + int'(ow), NWIN - 2);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(int r, logic [DATA_W-1:0] d); step(0, 0, 1, r, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd(int a, int b); step(a, b, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_save(); step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic do_rest(); step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic ld(int a, int b, int c); step(0, 0, 0, 0, 0, 0, 0, 1, a, b, c); endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_mem[i] = '0; end
    m_cwp = 0; m_cs = NWIN - 2; m_cr = 0; m_ow = 0;
    rst_n = 0; rda = 0; rdb = 0; we = 0; wa = 0; wd = 0;
    sv = 0; rs = 0; cw = 0; cs_ld = 0; cr_ld = 0; ow_ld = 0;
    #(PERIOD * 3);
    // R10 reset state
    chk(cwp == 0 && cs == CWP_W'(NWIN - 2) && cr == 0 && ow == 0 && !ovf && !unf,
        "R10", {cwp, cs, cr, ow}, {3'd0, 3'(NWIN - 2), 3'd0, 3'd0});
    @(negedge clk); rst_n = 1;

    do_rest();                             // R8 underflow from reset
    wr(0, 32'hDEAD_BEEF); rd(0, 0);        // R1
    wr(3, 32'h0000_0333);                  // R2
    wr(9, 32'h0000_0909);                  // out1 of window 0
    wr(17, 32'h0000_1717);                 // local1 of window 0
    step(25, 9, 1, 12, 32'h1212_0000, 1, 0, 0, 0, 0, 0); // write out4 with save (R14)
    rd(25, 3);                             // R3 in1 of window1, R2 global
    rd(28, 17);                            // R3 in4, R4 local not shared
    wr(17, 32'hAAAA_0001); do_rest(); rd(17, 9);         // R4 window 0 local intact
    for (int i = 0; i < NWIN - 2; i++) do_save();
    do_save();                             // R6 overflow
    rd(3, 0);
    ld(1, 5, 0); do_save();                // to window 7 via load (R12)
    wr(10, 32'h7777_000A);
    ld(1, 6, 0);                           // R12 invalid sum, ignored
    ld(1, 5, 0); do_save();                // wrap to window 0
    rd(26, 3);                             // R3 wrap alias
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, 6, 0); // R12 load wins over save
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0); // R13 both requested
    step(20, 20, 1, 20, 32'h5A5A_5A5A, 0, 0, 0, 0, 0, 0); // R11 bypass
    rd(20, 0);

    for (int n = 0; n < 6000; n++) begin
      int k, c_s, c_r;
      k = $urandom_range(0, 99);
      if (k < 5) begin
        c_s = $urandom_range(0, NWIN - 2);
        c_r = $urandom_range(0, NWIN - 2 - c_s);
        if (k == 0) ld(c_s, c_r, NWIN - 1 - c_s - c_r);
        else ld(c_s, c_r, NWIN - 2 - c_s - c_r);
      end else begin
        int ra, rb;
        bit ww;
        ra = $urandom_range(0, 31);
        rb = $urandom_range(0, 31);
        ww = ($urandom_range(0, 2) != 0);
        step(ra, rb, ww, (k < 20) ? ra : $urandom_range(0, 31), $urandom,
             (k >= 60 && k < 78), (k >= 72 && k < 95), 0, 0, 0, 0);
      end
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule